// File: doc/BRIEF.md
# USB Wakeup Interrupt and Power-State Controller

This block is the register-mapped glue that sits next to a USB dual-role controller. It watches two wakeup sources, one for the high-speed (HS) link and one for the super-speed (SS) link. Each source latches a raw wake status bit. A per-source enable and mask then qualify that bit onto an active-high, level-sensitive interrupt line. Software removes a pending status by writing the source's clear bit high and then low again. The block acts on the falling transition of that bit.

The block also takes a requested device power state, D0 (code 0) or D3 (code 3), and reports the state that the USB2 and USB3 power management units have reached. Each unit is modelled as a follower that adopts the request a fixed, per-unit number of cycles after the request changes, and only while the power-event enable is set. Software polls until both fields match the request. A sticky USB2-only mode bit is driven straight out to the rest of the subsystem.

Register map: host group at `HOST_BASE`, with status at +0x0 and configuration at +0x4. Interrupt group at `INT_BASE`, with configuration at +0x0, status at +0x4 and top control at +0xC. The defaults are 0x00 and 0x10.

Top module: `usb_wake_pm_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0. Both interrupt outputs and `usb2_only` are low, and both power-state fields read D0.
- R2: Host configuration keeps the power-event enable at bit 3 and the request at bits 5:4. Interrupt configuration keeps the HS/SS masks at bits 2/3, the enables at bits 8/9 and the clears at bits 14/15. All other bits of these registers ignore writes and read 0.
- R3: A one-cycle pulse on `hs_pme_evt` or `ss_pme_evt` sets bit 2 or bit 3 of interrupt status, and the bit stays set until cleared. This happens even while the source is masked or disabled.
- R4: An interrupt output is high exactly while its raw status is 1, its enable bit is 1 and its mask bit is 0.
- R5: A status bit clears on the clock edge after its clear bit goes from 1 to 0. Holding the clear bit at 1 never clears it.
- R6: When a wake event arrives in the same cycle as a clear, the status bit stays set.
- R7: Host status reports the USB2 state at bits 1:0 and the USB3 state at bits 4:3. With the enable set, each field takes the written request exactly its own latency plus one cycles after the write edge.
- R8: While the power-event enable is 0, neither power-state field changes.
- R9: The top control bit 5 holds its written value and drives `usb2_only`. The other bits of that register read 0.
- R10: Writes to the two status registers and to unmapped addresses change nothing, and unmapped addresses read 0.
- R11: The HS and SS sources are independent: an event, a clear or a configuration change on one never changes the other's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| hs_pme_evt | input | 1 | HS wake event pulse |
| ss_pme_evt | input | 1 | SS wake event pulse |
| hs_pme_irq | output | 1 | HS wake interrupt, active high level |
| ss_pme_irq | output | 1 | SS wake interrupt, active high level |
| usb2_only | output | 1 | USB2-only mode |

## Verification
The bench builds the block with a USB2 follower latency of 3 and a USB3 latency of 6. Because the two latencies differ, the status register passes through a visible intermediate state in which only the USB2 field has reached D3. This lets the bench check each field's settling cycle separately. It also shows that completion waits for both fields. The short latencies keep every power-state wait to a handful of cycles, which leaves room for the clear-sequence and event-versus-clear races at exact edges.

// File: rtl/usbwk_pkg.sv
package usbwk_pkg;

    localparam int NUM_SRC = 2;
    localparam int SRC_HS  = 0;
    localparam int SRC_SS  = 1;
    localparam int DATA_W  = 32;

    typedef logic [1:0] pstate_t;
    localparam pstate_t PS_D0 = 2'd0;
    localparam pstate_t PS_D3 = 2'd3;

    // register offsets inside each group
    localparam int HC_STAT_OFS = 0;
    localparam int HC_CFG_OFS  = 4;
    localparam int IC_CFG_OFS  = 0;
    localparam int IC_STAT_OFS = 4;
    localparam int IC_TOP_OFS  = 12;

    // field positions
    localparam int HC_EN_BIT      = 3;
    localparam int HC_REQ_LSB     = 4;
    localparam int ST_U2_LSB      = 0;
    localparam int ST_U3_LSB      = 3;
    localparam int IC_MSK_LSB     = 2;
    localparam int IC_EN_LSB      = 8;
    localparam int IC_CLR_LSB     = 14;
    localparam int IS_RAW_LSB     = 2;
    localparam int TOP_U2ONLY_BIT = 5;

    localparam logic [DATA_W-1:0] HC_CFG_WMASK = 32'h0000_0038;
    localparam logic [DATA_W-1:0] IC_CFG_WMASK = 32'h0000_C30C;
    localparam logic [DATA_W-1:0] TOP_WMASK    = 32'h0000_0020;

    typedef struct packed {
        logic    pme_en;
        pstate_t req;
    } host_cfg_t;

    typedef struct packed {
        logic msk;
        logic en;
        logic clr;
    } src_cfg_t;

    function automatic host_cfg_t host_cfg_unpack(logic [DATA_W-1:0] w);
        host_cfg_t c;
        c.pme_en = w[HC_EN_BIT];
        c.req    = w[HC_REQ_LSB +: 2];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] host_cfg_pack(host_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[HC_EN_BIT]       = c.pme_en;
        w[HC_REQ_LSB +: 2] = c.req;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] host_stat_pack(pstate_t u2, pstate_t u3);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_U2_LSB +: 2] = u2;
        w[ST_U3_LSB +: 2] = u3;
        return w;
    endfunction

    function automatic src_cfg_t src_cfg_get(logic [DATA_W-1:0] w, int idx);
        src_cfg_t c;
        c.msk = w[IC_MSK_LSB + idx];
        c.en  = w[IC_EN_LSB + idx];
        c.clr = w[IC_CLR_LSB + idx];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] src_cfg_put(src_cfg_t c, int idx);
        logic [DATA_W-1:0] w;
        w = '0;
        w[IC_MSK_LSB + idx] = c.msk;
        w[IC_EN_LSB + idx]  = c.en;
        w[IC_CLR_LSB + idx] = c.clr;
        return w;
    endfunction

endpackage

// File: rtl/usbwk_pme_src.sv
module usbwk_pme_src
    import usbwk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt,
    input  src_cfg_t cfg,
    output logic     raw,
    output logic     irq
);

    logic clr_q;
    logic clr_fall;

    assign clr_fall = clr_q & ~cfg.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= 1'b0;
            raw   <= 1'b0;
        end else begin
            clr_q <= cfg.clr;
            if (evt) begin
                raw <= 1'b1;
            end else if (clr_fall) begin
                raw <= 1'b0;
            end
        end
    end

    assign irq = raw & cfg.en & ~cfg.msk;

endmodule

// File: rtl/usbwk_pmu_follow.sv
module usbwk_pmu_follow
    import usbwk_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pme_en,
    input  pstate_t req,
    output pstate_t cur
);

    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    logic [CNT_W-1:0] cnt;
    pstate_t          req_q;
    pstate_t          cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            req_q <= PS_D0;
            cur_q <= PS_D0;
        end else begin
            req_q <= req;
            if (!pme_en || (req == cur_q) || (req != req_q)) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                cur_q <= req;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/usbwk_csr.sv
module usbwk_csr
    import usbwk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int HOST_BASE = 'h00,
    parameter int INT_BASE  = 'h10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [NUM_SRC-1:0]        raw,
    input  pstate_t                   u2_state,
    input  pstate_t                   u3_state,
    output host_cfg_t                 hcfg,
    output src_cfg_t [NUM_SRC-1:0]    scfg,
    output logic                      usb2_only
);

    localparam logic [ADDR_W-1:0] A_HC_STAT = ADDR_W'(HOST_BASE + HC_STAT_OFS);
    localparam logic [ADDR_W-1:0] A_HC_CFG  = ADDR_W'(HOST_BASE + HC_CFG_OFS);
    localparam logic [ADDR_W-1:0] A_IC_CFG  = ADDR_W'(INT_BASE + IC_CFG_OFS);
    localparam logic [ADDR_W-1:0] A_IC_STAT = ADDR_W'(INT_BASE + IC_STAT_OFS);
    localparam logic [ADDR_W-1:0] A_IC_TOP  = ADDR_W'(INT_BASE + IC_TOP_OFS);

    host_cfg_t             hcfg_q;
    src_cfg_t [NUM_SRC-1:0] scfg_q;
    logic                  u2only_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcfg_q   <= '0;
            scfg_q   <= '0;
            u2only_q <= 1'b0;
        end else if (we) begin
            case (addr)
                A_HC_CFG: hcfg_q <= host_cfg_unpack(wdata);
                A_IC_CFG: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        scfg_q[i] <= src_cfg_get(wdata, i);
                    end
                end
                A_IC_TOP: u2only_q <= wdata[TOP_U2ONLY_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_HC_STAT: rdata = host_stat_pack(u2_state, u3_state);
            A_HC_CFG:  rdata = host_cfg_pack(hcfg_q);
            A_IC_CFG: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    rdata = rdata | src_cfg_put(scfg_q[i], i);
                end
            end
            A_IC_STAT: rdata[IS_RAW_LSB +: NUM_SRC] = raw;
            A_IC_TOP:  rdata[TOP_U2ONLY_BIT] = u2only_q;
            default:   rdata = '0;
        endcase
    end

    assign hcfg      = hcfg_q;
    assign scfg      = scfg_q;
    assign usb2_only = u2only_q;

endmodule

// File: rtl/usb_wake_pm_ctrl.sv
module usb_wake_pm_ctrl
    import usbwk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int HOST_BASE = 'h00,
    parameter int INT_BASE  = 'h10,
    parameter int U2_LAT    = 4,
    parameter int U3_LAT    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              hs_pme_evt,
    input  logic              ss_pme_evt,
    output logic              hs_pme_irq,
    output logic              ss_pme_irq,
    output logic              usb2_only
);

    localparam int NUM_PMU = 2;

    logic [NUM_SRC-1:0]     evt_w;
    logic [NUM_SRC-1:0]     raw_w;
    logic [NUM_SRC-1:0]     irq_w;
    host_cfg_t              hcfg_w;
    src_cfg_t [NUM_SRC-1:0] scfg_w;
    pstate_t [NUM_PMU-1:0]  pmu_w;
    pstate_t                u2_w;
    pstate_t                u3_w;

    assign evt_w[SRC_HS] = hs_pme_evt;
    assign evt_w[SRC_SS] = ss_pme_evt;
    assign hs_pme_irq    = irq_w[SRC_HS];
    assign ss_pme_irq    = irq_w[SRC_SS];
    assign u2_w          = pmu_w[0];
    assign u3_w          = pmu_w[1];

    usbwk_csr #(
        .ADDR_W   (ADDR_W),
        .HOST_BASE(HOST_BASE),
        .INT_BASE (INT_BASE)
    ) csr_i (
        .clk      (clk),
        .rst      (rst),
        .we       (csr_we),
        .addr     (csr_addr),
        .wdata    (csr_wdata),
        .rdata    (csr_rdata),
        .raw      (raw_w),
        .u2_state (u2_w),
        .u3_state (u3_w),
        .hcfg     (hcfg_w),
        .scfg     (scfg_w),
        .usb2_only(usb2_only)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        usbwk_pme_src src_i (
            .clk(clk),
            .rst(rst),
            .evt(evt_w[s]),
            .cfg(scfg_w[s]),
            .raw(raw_w[s]),
            .irq(irq_w[s])
        );
    end

    for (genvar k = 0; k < NUM_PMU; k++) begin : g_pmu
        localparam int LAT_K = (k == 0) ? U2_LAT : U3_LAT;
        usbwk_pmu_follow #(.LAT(LAT_K)) pmu_i (
            .clk   (clk),
            .rst   (rst),
            .pme_en(hcfg_w.pme_en),
            .req   (hcfg_w.req),
            .cur   (pmu_w[k])
        );
    end

endmodule

// File: rtl/usbwk_chk.sv
module usbwk_chk
    import usbwk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int HOST_BASE = 'h00,
    parameter int INT_BASE  = 'h10
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   csr_we,
    input logic [ADDR_W-1:0]      csr_addr,
    input logic [31:0]            csr_rdata,
    input logic [NUM_SRC-1:0]     evt,
    input logic [NUM_SRC-1:0]     raw,
    input logic [NUM_SRC-1:0]     irq,
    input host_cfg_t              hcfg,
    input src_cfg_t [NUM_SRC-1:0] scfg,
    input pstate_t                u2,
    input pstate_t                u3,
    input logic                   usb2_only
);

    localparam logic [ADDR_W-1:0] A_HC_CFG = ADDR_W'(HOST_BASE + HC_CFG_OFS);
    localparam logic [ADDR_W-1:0] A_IC_TOP = ADDR_W'(INT_BASE + IC_TOP_OFS);

    logic [NUM_SRC-1:0] clr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_prev <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                clr_prev[i] <= scfg[i].clr;
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
        // R3 and R6: an event always leaves the status set
        p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> raw[i]);
        // R5: status survives unless a 1-to-0 clear transition is seen
        p_clear_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
            (raw[i] && !(clr_prev[i] && !scfg[i].clr)) |=> raw[i]);
        // R4: masked or disabled source never interrupts
        p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
            (scfg[i].msk || !scfg[i].en) |-> !irq[i]);
    end

    // R7: a PMU field only moves onto the request that was standing
    p_u2_to_req_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(u2) |-> (u2 == $past(hcfg.req)));
    p_u3_to_req_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(u3) |-> (u3 == $past(hcfg.req)));
    // R8: no movement while the enable is off
    p_u2_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(hcfg.pme_en) |-> $stable(u2));
    p_u3_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(hcfg.pme_en) |-> $stable(u3));
    // R9: mode bit changes only through a write to its register
    p_u2only_write_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(usb2_only) |-> $past(csr_we && (csr_addr == A_IC_TOP)));
    // R2: reserved host configuration bits read 0
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == A_HC_CFG) |-> ((csr_rdata & ~HC_CFG_WMASK) == '0));

endmodule

bind usb_wake_pm_ctrl usbwk_chk #(
    .ADDR_W   (ADDR_W),
    .HOST_BASE(HOST_BASE),
    .INT_BASE (INT_BASE)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .csr_we   (csr_we),
    .csr_addr (csr_addr),
    .csr_rdata(csr_rdata),
    .evt      (evt_w),
    .raw      (raw_w),
    .irq      (irq_w),
    .hcfg     (hcfg_w),
    .scfg     (scfg_w),
    .u2       (u2_w),
    .u3       (u3_w),
    .usb2_only(usb2_only)
);

// File: tb/usb_wake_pm_ctrl_tb_top.sv
module usb_wake_pm_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int U2_LAT     = 3;
    localparam int U3_LAT     = 6;

    localparam logic [7:0] A_HSTAT = 8'h00;
    localparam logic [7:0] A_HCFG  = 8'h04;
    localparam logic [7:0] A_ICFG  = 8'h10;
    localparam logic [7:0] A_ISTAT = 8'h14;
    localparam logic [7:0] A_TOP   = 8'h1C;

    localparam int NVEC = 10;
    // {req id, addr, write data, expected readback}
    localparam logic [75:0] VEC [NVEC] = '{
        {4'd2,  8'h04, 32'hFFFF_FFFF, 32'h0000_0038},
        {4'd2,  8'h04, 32'h0000_0008, 32'h0000_0008},
        {4'd2,  8'h04, 32'h0000_0030, 32'h0000_0030},
        {4'd2,  8'h10, 32'hFFFF_FFFF, 32'h0000_C30C},
        {4'd2,  8'h10, 32'h0000_0104, 32'h0000_0104},
        {4'd9,  8'h1C, 32'hFFFF_FFFF, 32'h0000_0020},
        {4'd9,  8'h1C, 32'h0000_0000, 32'h0000_0000},
        {4'd10, 8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd10, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd10, 8'h08, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_we = 1'b0;
    logic [ADDR_W-1:0] csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic              hs_pme_evt = 1'b0;
    logic              ss_pme_evt = 1'b0;
    logic              hs_pme_irq;
    logic              ss_pme_irq;
    logic              usb2_only;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_wake_pm_ctrl #(
        .ADDR_W(ADDR_W),
        .U2_LAT(U2_LAT),
        .U3_LAT(U3_LAT)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .hs_pme_evt(hs_pme_evt),
        .ss_pme_evt(ss_pme_evt),
        .hs_pme_irq(hs_pme_irq),
        .ss_pme_irq(ss_pme_irq),
        .usb2_only (usb2_only)
    );

    function automatic string req_name(logic [3:0] id);
        case (id)
            4'd2:    return "R2";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic pulse_evt(bit hs, bit ss);
        @(negedge clk);
        hs_pme_evt = hs;
        ss_pme_evt = ss;
        @(negedge clk);
        hs_pme_evt = 1'b0;
        ss_pme_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        rd(A_HSTAT, v); check("R1 host status", v, 32'h0);
        rd(A_HCFG, v);  check("R1 host cfg", v, 32'h0);
        rd(A_ICFG, v);  check("R1 int cfg", v, 32'h0);
        rd(A_ISTAT, v); check("R1 int status", v, 32'h0);
        rd(A_TOP, v);   check("R1 top ctrl", v, 32'h0);
        check("R1 irqs", {30'h0, hs_pme_irq, ss_pme_irq}, 32'h0);
        check("R1 usb2_only", {31'h0, usb2_only}, 32'h0);

        // table walk: R2, R9, R10 register behaviour
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check(req_name(VEC[i][75:72]), v, VEC[i][31:0]);
        end
        wr(A_HCFG, 32'h0);
        wr(A_ICFG, 32'h0);

        // R3/R4: HS enabled, event raises status and irq
        wr(A_ICFG, 32'h0000_0100);
        pulse_evt(1'b1, 1'b0);
        rd(A_ISTAT, v); check("R3 hs raw set", v, 32'h4);
        check("R4 hs irq on", {31'h0, hs_pme_irq}, 32'h1);
        check("R11 ss irq idle", {31'h0, ss_pme_irq}, 32'h0);
        // R4: mask drops irq, status kept
        wr(A_ICFG, 32'h0000_0104);
        check("R4 masked irq off", {31'h0, hs_pme_irq}, 32'h0);
        rd(A_ISTAT, v); check("R4 raw kept while masked", v, 32'h4);
        // R3: SS event captured while disabled
        pulse_evt(1'b0, 1'b1);
        rd(A_ISTAT, v); check("R3 ss captured disabled", v, 32'hC);
        check("R4 ss disabled irq off", {31'h0, ss_pme_irq}, 32'h0);
        wr(A_ICFG, 32'h0000_0300);
        check("R4 both irqs", {30'h0, hs_pme_irq, ss_pme_irq}, 32'h3);

        // R5: holding clear at 1 keeps status
        wr(A_ICFG, 32'h0000_4300);
        repeat (3) @(negedge clk);
        rd(A_ISTAT, v); check("R5 held clear no effect", v, 32'hC);
        wr(A_ICFG, 32'h0000_0300);
        @(negedge clk);
        rd(A_ISTAT, v); check("R5 hs cleared after fall", v, 32'h8);
        check("R11 ss irq unaffected", {30'h0, hs_pme_irq, ss_pme_irq}, 32'h1);

        // R6: event coinciding with clear wins
        wr(A_ICFG, 32'h0000_8300);
        wr(A_ICFG, 32'h0000_0300);
        ss_pme_evt = 1'b1;
        @(negedge clk);
        ss_pme_evt = 1'b0;
        @(negedge clk);
        rd(A_ISTAT, v); check("R6 event beats clear", v, 32'h8);
        wr(A_ICFG, 32'h0000_8300);
        wr(A_ICFG, 32'h0000_0300);
        @(negedge clk);
        rd(A_ISTAT, v); check("R5 ss cleared", v, 32'h0);

        // R7: D3 request, distinct follower latencies
        wr(A_HCFG, 32'h0000_0038);
        repeat (U2_LAT) @(negedge clk);
        rd(A_HSTAT, v); check("R7 u2 not yet", v, 32'h00);
        @(negedge clk);
        rd(A_HSTAT, v); check("R7 u2 reached D3", v, 32'h03);
        repeat (U3_LAT - U2_LAT - 1) @(negedge clk);
        rd(A_HSTAT, v); check("R7 u3 not yet", v, 32'h03);
        @(negedge clk);
        rd(A_HSTAT, v); check("R7 both D3", v, 32'h1B);

        // R8: enable off, request D0, nothing moves
        wr(A_HCFG, 32'h0000_0000);
        repeat (3 * U3_LAT) @(negedge clk);
        rd(A_HSTAT, v); check("R8 frozen without enable", v, 32'h1B);
        wr(A_HCFG, 32'h0000_0008);
        repeat (U3_LAT + 2) @(negedge clk);
        rd(A_HSTAT, v); check("R7 back to D0", v, 32'h00);

        // R9: sticky mode bit
        wr(A_TOP, 32'h0000_0020);
        check("R9 usb2_only set", {31'h0, usb2_only}, 32'h1);
        wr(A_HCFG, 32'h0000_0038);
        wr(A_ICFG, 32'h0000_0000);
        repeat (5) @(negedge clk);
        rd(A_TOP, v); check("R9 mode kept", v, 32'h20);
        check("R9 usb2_only kept", {31'h0, usb2_only}, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule